// File: doc/BRIEF.md
# Scan-Register to Peripheral-Bus Command Bridge

This block sits behind a 64-bit register port and turns writes to one of its registers into single 32-bit transactions on an on-chip peripheral bus. Software first loads a data word for writes. It then writes a command word that carries the bus address, a 4-bit transfer size and a read flag. The bridge launches the bus operation at once. When the bus answers, the bridge records the outcome in a status register, which software polls.

The port decodes four 8-byte registers from byte-address bits [4:3]. Only full 8-byte accesses take effect. Read results are packed big-endian into a 32-bit field of the status word, next to a done flag. A failed read fills that field with ones. Reading the status register clears it. The bus side uses a simple request/acknowledge handshake, and a transfer can complete with either an acknowledge or an error.

Top module: `scanbus_bridge`

## Requirements
- R1: The register is selected by `reg_addr[4:3]`: 0 = command, 1 = reset, 2 = status, 3 = data. All other address bits are ignored.
- R2: An access counts only when `reg_be` is 8'hFF. A partial access changes no state, and a partial read returns zero on `reg_rdata`.
- R3: A full write to the command register while idle raises `pb_req` on the next cycle, with `pb_addr` = wdata[31:0], `pb_size` = wdata[59:56] and `pb_we` = NOT wdata[48]. `pb_wdata` carries the data register value at launch, most significant byte in bits [31:24].
- R4: `pb_req` and all request fields hold steady until `pb_ack` or `pb_err` is sampled high. `pb_req` is low in the following cycle.
- R5: A read that completes with `pb_ack` sets status to bit 11 OR (`pb_rdata` shifted left by 26).
- R6: A read that completes with `pb_err` sets status to bit 11 OR (32'hFFFFFFFF shifted left by 26).
- R7: A write that completes, by acknowledge or by error, sets status to exactly 64'h800.
- R8: A full status read returns the status value on `reg_rdata` in the cycle after the access and clears the status to zero. If a completion lands in the same cycle, the new status is kept. Writes to the status register are ignored.
- R9: A full data write stores wdata[63:32]. A data read returns {stored value, 32'h0}.
- R10: Reads of the command and reset registers return zero. Writes to the reset register have no effect.
- R11: A command write while `pb_req` is high is ignored.
- R12: After reset, `pb_req` is low and the status and data registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe, one cycle per access |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address; bits [4:3] select the register |
| reg_be | input | 8 | Byte enables; only 8'hFF is accepted |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after a read access, zero otherwise |
| pb_req | output | 1 | Bus request, held until completion |
| pb_we | output | 1 | 1 = bus write |
| pb_addr | output | 32 | Bus address |
| pb_size | output | 4 | Transfer size field from the command word |
| pb_wdata | output | 32 | Bus write data, big-endian byte order |
| pb_rdata | input | 32 | Bus read data, sampled with pb_ack |
| pb_ack | input | 1 | Successful completion pulse |
| pb_err | input | 1 | Failed completion pulse |

## Verification
The assertions assume that the bus side raises `pb_ack` or `pb_err` only while `pb_req` is high, and only as a single-cycle pulse that ends before any new request. They also assume that `reg_valid` is a one-cycle strobe with stable fields. The bench bus responder keeps to this. It counts a programmable latency only while a request is visible, drives exactly one completion pulse, and returns to idle before the bridge can launch again. Register accesses are driven on the falling edge and dropped one cycle later.

// File: rtl/scanbus_pkg.sv
package scanbus_pkg;
    localparam int WORD_W     = 64;
    localparam int BE_W       = WORD_W / 8;
    localparam int BUS_AW     = 32;
    localparam int BUS_DW     = 32;
    localparam int SIZE_W     = 4;
    localparam int SEL_LSB    = 3;
    localparam int SEL_W      = 2;
    localparam int RDFLAG_POS = 48;
    localparam int SIZE_LSB   = 56;
    localparam int DONE_POS   = 11;
    localparam int RDATA_LSB  = 26;
    localparam int HALF_W     = WORD_W / 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD  = 2'd0,
        SEL_RST  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_DATA = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              is_read;
        logic [SIZE_W-1:0] size;
        logic [BUS_AW-1:0] addr;
    } cmd_t;
endpackage

// File: rtl/scanbus_decode.sv
module scanbus_decode
    import scanbus_pkg::*;
(
    input  logic             valid,
    input  logic             write,
    input  logic [BE_W-1:0]  be,
    input  logic [SEL_W-1:0] sel_bits,
    output logic             rd_en,
    output logic             wr_en,
    output reg_sel_e         sel
);
    logic full;

    always_comb begin
        full  = &be;
        rd_en = valid & full & ~write;
        wr_en = valid & full & write;
        sel   = reg_sel_e'(sel_bits);
    end
endmodule

// File: rtl/scanbus_cmd_unpack.sv
module scanbus_cmd_unpack
    import scanbus_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cmd_t              cmd,
    output logic [HALF_W-1:0] hi_half
);
    always_comb begin
        cmd.is_read = word[RDFLAG_POS];
        cmd.size    = word[SIZE_LSB +: SIZE_W];
        cmd.addr    = word[0 +: BUS_AW];
        hi_half     = word[HALF_W +: HALF_W];
    end
endmodule

// File: rtl/scanbus_stat_pack.sv
module scanbus_stat_pack
    import scanbus_pkg::*;
(
    input  logic              is_write,
    input  logic              failed,
    input  logic [BUS_DW-1:0] bus_rdata,
    output logic [WORD_W-1:0] status
);
    localparam int LANES = BUS_DW / 8;

    logic [BUS_DW-1:0] be_word;

    // lane 0 is the first byte on the bus and lands in the top byte
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign be_word[BUS_DW-1-8*b -: 8] = bus_rdata[BUS_DW-1-8*b -: 8];
    end

    always_comb begin
        status           = '0;
        status[DONE_POS] = 1'b1;
        if (!is_write) begin
            status[RDATA_LSB +: BUS_DW] = failed ? {BUS_DW{1'b1}} : be_word;
        end
    end
endmodule

// File: rtl/scanbus_bridge.sv
module scanbus_bridge
    import scanbus_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BE_W-1:0]   reg_be,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              pb_req,
    output logic              pb_we,
    output logic [BUS_AW-1:0] pb_addr,
    output logic [SIZE_W-1:0] pb_size,
    output logic [BUS_DW-1:0] pb_wdata,
    input  logic [BUS_DW-1:0] pb_rdata,
    input  logic              pb_ack,
    input  logic              pb_err
);
    typedef struct packed {
        logic              busy;
        logic              we;
        logic [SIZE_W-1:0] size;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] wdata;
        logic [HALF_W-1:0] data;
        logic [WORD_W-1:0] stat;
        logic [WORD_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic              rd_en, wr_en;
    reg_sel_e          sel;
    cmd_t              cmd;
    logic [HALF_W-1:0] wr_hi;
    logic [WORD_W-1:0] done_word;
    logic              complete;
    logic [WORD_W-1:0] stat_q_w;

    scanbus_decode u_dec (
        .valid    (reg_valid),
        .write    (reg_write),
        .be       (reg_be),
        .sel_bits (reg_addr[SEL_LSB +: SEL_W]),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .sel      (sel)
    );

    scanbus_cmd_unpack u_cmd (
        .word    (reg_wdata),
        .cmd     (cmd),
        .hi_half (wr_hi)
    );

    scanbus_stat_pack u_stat (
        .is_write  (st_q.we),
        .failed    (pb_err),
        .bus_rdata (pb_rdata),
        .status    (done_word)
    );

    always_comb begin
        st_d     = st_q;
        complete = st_q.busy & (pb_ack | pb_err);

        if (complete) begin
            st_d.busy = 1'b0;
            st_d.stat = done_word;
        end

        st_d.rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_STAT: begin
                    st_d.rdata = st_q.stat;
                    if (!complete) st_d.stat = '0;
                end
                SEL_DATA: st_d.rdata = {st_q.data, {HALF_W{1'b0}}};
                default:  st_d.rdata = '0;
            endcase
        end

        if (wr_en) begin
            unique case (sel)
                SEL_CMD: begin
                    if (!st_q.busy) begin
                        st_d.busy  = 1'b1;
                        st_d.we    = ~cmd.is_read;
                        st_d.size  = cmd.size;
                        st_d.addr  = cmd.addr;
                        st_d.wdata = st_q.data;
                    end
                end
                SEL_DATA: st_d.data = wr_hi;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign pb_req    = st_q.busy;
    assign pb_we     = st_q.we;
    assign pb_addr   = st_q.addr;
    assign pb_size   = st_q.size;
    assign pb_wdata  = st_q.wdata;
    assign stat_q_w  = st_q.stat;
endmodule

// File: rtl/scanbus_bridge_chk.sv
module scanbus_bridge_chk
    import scanbus_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BE_W-1:0]   reg_be,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              pb_req,
    input logic              pb_we,
    input logic [BUS_AW-1:0] pb_addr,
    input logic [SIZE_W-1:0] pb_size,
    input logic [BUS_DW-1:0] pb_wdata,
    input logic              pb_ack,
    input logic              pb_err,
    input logic [WORD_W-1:0] stat
);
    logic       full, fin;
    logic [1:0] rsel;

    assign full = &reg_be;
    assign fin  = pb_req & (pb_ack | pb_err);
    assign rsel = reg_addr[SEL_LSB +: SEL_W];

    assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pb_req && reg_valid && reg_write && full && rsel == 2'd0 |=> pb_req);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pb_req && !(pb_ack || pb_err) |=> pb_req);

    assert_fields_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pb_req && !(pb_ack || pb_err) |=>
            $stable(pb_addr) && $stable(pb_size) && $stable(pb_we) && $stable(pb_wdata));

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !pb_req);

    assert_partial_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && !reg_write && !full |=> reg_rdata == '0);

    assert_write_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fin && pb_we |=> stat == 64'h800);

    assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && !reg_write && full && rsel == 2'd2 && !fin |=> stat == '0);

    assert_data_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && !reg_write && full && rsel == 2'd3 |=> reg_rdata[HALF_W-1:0] == '0);

    assert_cmd_rst_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && !reg_write && full && rsel[1] == 1'b0 |=> reg_rdata == '0);

    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pb_req && !(pb_ack || pb_err) && reg_valid && reg_write && rsel == 2'd0
            |=> $stable(pb_addr));
endmodule

bind scanbus_bridge scanbus_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_be    (reg_be),
    .reg_rdata (reg_rdata),
    .pb_req    (pb_req),
    .pb_we     (pb_we),
    .pb_addr   (pb_addr),
    .pb_size   (pb_size),
    .pb_wdata  (pb_wdata),
    .pb_ack    (pb_ack),
    .pb_err    (pb_err),
    .stat      (stat_q_w)
);

// File: tb/sim_scanbus_bridge.sv
module sim_scanbus_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int WATCHDOG   = 20000;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_valid = 0;
    logic        reg_write = 0;
    logic [7:0]  reg_addr = 0;
    logic [7:0]  reg_be = 0;
    logic [63:0] reg_wdata = 0;
    logic [63:0] reg_rdata;
    logic        pb_req, pb_we;
    logic [31:0] pb_addr, pb_wdata;
    logic [3:0]  pb_size;
    logic [31:0] pb_rdata = 0;
    logic        pb_ack = 0;
    logic        pb_err = 0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scanbus_bridge #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pb_req(pb_req), .pb_we(pb_we), .pb_addr(pb_addr), .pb_size(pb_size),
        .pb_wdata(pb_wdata), .pb_rdata(pb_rdata), .pb_ack(pb_ack), .pb_err(pb_err)
    );

    // bus responder
    int          slv_lat  = 2;
    bit          slv_fail = 0;
    logic [31:0] slv_data = 32'h0;
    int          slv_cnt  = 0;

    always @(negedge clk) begin
        if (pb_ack || pb_err) begin
            pb_ack  <= 0;
            pb_err  <= 0;
            slv_cnt <= 0;
        end else if (pb_req && rst_n) begin
            if (slv_cnt >= slv_lat) begin
                if (slv_fail) begin
                    pb_err   <= 1;
                    pb_rdata <= 32'h5A5A5A5A;
                end else begin
                    pb_ack   <= 1;
                    pb_rdata <= slv_data;
                end
            end else begin
                slv_cnt <= slv_cnt + 1;
            end
        end
    end

    // behavioural reference model, advanced on every rising edge
    bit          m_req = 0, m_we = 0;
    logic [31:0] m_addr = 0, m_wd = 0, m_data = 0;
    logic [3:0]  m_size = 0;
    logic [63:0] m_stat = 0, m_rd = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_req <= 0; m_we <= 0; m_addr <= 0; m_wd <= 0; m_data <= 0;
            m_size <= 0; m_stat <= 0; m_rd <= 0;
        end else begin
            bit          ok, fin;
            int          which;
            logic [63:0] ns;
            ok    = reg_valid && (reg_be == 8'hFF);
            which = int'(reg_addr[4:3]);
            fin   = m_req && (pb_ack || pb_err);
            ns    = m_stat;
            if (fin) begin
                m_req <= 0;
                if (m_we) ns = 64'h800;
                else if (pb_err) ns = 64'h800 | (64'hFFFFFFFF << 26);
                else ns = 64'h800 | (64'(pb_rdata) << 26);
            end
            m_rd <= 64'h0;
            if (ok && !reg_write) begin
                if (which == 2) begin
                    m_rd <= m_stat;
                    if (!fin) ns = 64'h0;
                end else if (which == 3) begin
                    m_rd <= {m_data, 32'h0};
                end
            end
            if (ok && reg_write) begin
                if (which == 0 && !m_req) begin
                    m_req  <= 1;
                    m_we   <= !reg_wdata[48];
                    m_size <= reg_wdata[59:56];
                    m_addr <= reg_wdata[31:0];
                    m_wd   <= m_data;
                end else if (which == 3) begin
                    m_data <= reg_wdata[63:32];
                end
            end
            m_stat <= ns;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (pb_req !== m_req) begin
                errors++;
                $display("FAIL R4 pb_req actual %0b expected %0b", pb_req, m_req);
            end
            checks++;
            if (reg_rdata !== m_rd) begin
                errors++;
                $display("FAIL R8 reg_rdata actual %h expected %h", reg_rdata, m_rd);
            end
            if (m_req) begin
                checks++;
                if ({pb_we, pb_size, pb_addr, pb_wdata} !== {m_we, m_size, m_addr, m_wd}) begin
                    errors++;
                    $display("FAIL R3 request actual %b/%h/%h/%h expected %b/%h/%h/%h",
                             pb_we, pb_size, pb_addr, pb_wdata, m_we, m_size, m_addr, m_wd);
                end
            end
        end
    end

    task automatic final_report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
            final_report();
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input logic [7:0] a, input logic [63:0] d,
                       input logic [7:0] be);
        reg_valid = 1; reg_write = wr; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_valid = 0; reg_write = 0; reg_be = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] be, output logic [63:0] v);
        acc(0, a, 64'h0, be);
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        while (pb_req) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R12: reset state
        chk(64'(pb_req), 64'h0, "R12 pb_req after reset");
        rd(8'h10, 8'hFF, v); chk(v, 64'h0, "R12 status after reset");
        rd(8'h18, 8'hFF, v); chk(v, 64'h0, "R12 data after reset");

        // R9 data register, R1 upper address bits ignored
        acc(1, 8'h18, 64'hA1B2C3D4_99887766, 8'hFF);
        rd(8'h18, 8'hFF, v); chk(v, 64'hA1B2C3D4_00000000, "R9 data readback");
        rd(8'hF8, 8'hFF, v); chk(v, 64'hA1B2C3D4_00000000, "R1 aliased data select");

        // R10 command and reset registers read zero, reset writes do nothing
        acc(1, 8'h08, 64'hFFFFFFFF_FFFFFFFF, 8'hFF);
        chk(64'(pb_req), 64'h0, "R10 reset write launches nothing");
        rd(8'h00, 8'hFF, v); chk(v, 64'h0, "R10 command read");
        rd(8'h08, 8'hFF, v); chk(v, 64'h0, "R10 reset read");

        // R3 + R5: bus read
        slv_lat = 3; slv_fail = 0; slv_data = 32'h11223344;
        acc(1, 8'h00, 64'h0401_0000_D001_0040, 8'hFF);
        chk(64'(pb_req), 64'h1, "R3 request raised");
        chk({31'h0, pb_we, 28'h0, pb_size}, {31'h0, 1'b0, 28'h0, 4'h4}, "R3 read direction and size");
        chk(64'(pb_addr), 64'hD0010040, "R3 address");
        wait_idle();
        rd(8'h10, 8'hFF, v); chk(v, 64'h800 | (64'h11223344 << 26), "R5 read status");
        rd(8'h10, 8'hFF, v); chk(v, 64'h0, "R8 status cleared by read");

        // R6: failed read
        slv_fail = 1; slv_lat = 1;
        acc(1, 8'h00, 64'h0201_0000_F000_0000, 8'hFF);
        wait_idle();
        rd(8'h10, 8'hFF, v); chk(v, 64'h800 | (64'hFFFFFFFF << 26), "R6 error status");

        // R7 + R11: bus write, command and data writes while busy
        slv_fail = 0; slv_lat = 6;
        acc(1, 8'h18, 64'hCAFEF00D_00000000, 8'hFF);
        acc(1, 8'h00, 64'h0400_0000_C001_2024, 8'hFF);
        chk(64'(pb_wdata), 64'hCAFEF00D, "R3 write data");
        chk(64'(pb_we), 64'h1, "R3 write direction");
        acc(1, 8'h00, 64'h0401_0000_1234_5678, 8'hFF);
        acc(1, 8'h18, 64'h01020304_00000000, 8'hFF);
        chk(64'(pb_addr), 64'hC0012024, "R11 address kept while busy");
        chk(64'(pb_wdata), 64'hCAFEF00D, "R11 write data kept while busy");
        wait_idle();
        chk(64'(pb_req), 64'h0, "R11 no second request");
        // R8 status writes ignored
        acc(1, 8'h10, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
        rd(8'h10, 8'hFF, v); chk(v, 64'h800, "R7 write status done only");

        // R7: write ending in error still reports done only
        slv_fail = 1; slv_lat = 0;
        acc(1, 8'h00, 64'h0400_0000_C001_2028, 8'hFF);
        wait_idle();
        // R2: partial status read neither returns nor clears
        rd(8'h10, 8'h0F, v); chk(v, 64'h0, "R2 partial read returns zero");
        rd(8'h10, 8'hFF, v); chk(v, 64'h800, "R7 write error status");

        // R2: partial writes have no effect
        acc(1, 8'h18, 64'hDEADBEEF_00000000, 8'hF0);
        rd(8'h18, 8'hFF, v); chk(v, 64'h01020304_00000000, "R2 partial data write ignored");
        acc(1, 8'h00, 64'h0401_0000_0000_0010, 8'h7F);
        chk(64'(pb_req), 64'h0, "R2 partial command write ignored");

        repeat (4) @(negedge clk);
        final_report();
    end
endmodule